// File: doc/BRIEF.md
# Transparent Serial Transmitter with RTS/CTS Handshake

This block sends unframed byte data as a bit stream on a TXD line. It handles the modem handshake around that stream. Bytes arrive on a valid/ready buffer port. Each byte carries two flags: one marks the last byte of its buffer, and one says the buffer closes a frame. The transmitter drives RTS low only when it has data and the synchronised CTS input is low. It sends one idle-level lead bit and then the bytes, LSB first, one bit per pulse of the external bit-clock enable. It releases RTS after the last byte of a frame-closing buffer.

Buffers that do not close a frame are chained with no gap on the line. Separate frames are kept at least seventeen bit times apart. If CTS rises while RTS is low, the transmission is aborted: the line returns to idle at once, the rest of the frame is drained from the buffer port, and an error status is reported. A two-bit diagnostic mode field can make the block ignore CTS. An external sync enable holds off all transmission until a synchronised sync input has been seen low.

Top module: `ttx_top`

## Requirements
- R1: After reset rts_n is 1, txd is 1, buf_ready is 0 and done_vld is 0. Whenever rts_n is 1, txd is 1.
- R2: rts_n goes low only while the synchronised cts_n is low (or CTS is ignored, see R8). While cts_n stays high, a waiting buffer is not consumed and rts_n stays high.
- R3: In the first bit time with rts_n low, txd is 1 (the lead bit). Data bits follow in the next bit times, LSB first, one bit per bit_en pulse. buf_data[0] of a byte is sent first.
- R4: When the last byte of a buffer that has buf_frame_end=1 has been sent, rts_n returns high in the next bit time. A done_vld pulse with done_err=0 is reported for each buffer. A buffer's last byte has buf_last=1.
- R5: When a buffer ends with buf_frame_end=0 and the next buffer is ready, rts_n stays low. The next buffer's bit 0 follows the previous bit 7 in the very next bit time.
- R6: Between two frames, rts_n stays high for at least 17 and at most 19 bit times.
- R7: If the synchronised cts_n is high while rts_n is low, rts_n and txd are both 1 within three clock cycles. A done_vld pulse with done_err=1 is reported. The remaining bytes up to the frame's last byte are accepted on buf_ready and are not transmitted.
- R8: With mode_diag equal to 2'b11, cts_n is treated as low, so a frame is sent while cts_n is high. rts_n is still driven normally.
- R9: With sync_en=1, rts_n stays high until the synchronised sync_n has been seen low. After that, a later high level on sync_n does not stop transmission. Clearing sync_en re-arms the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Transmit bit-clock enable, one pulse per bit time |
| mode_diag | input | 2 | Diagnostic mode; 2'b11 ignores CTS |
| sync_en | input | 1 | Wait for the external sync before any transmission |
| sync_n | input | 1 | Active-low external sync input (asynchronous) |
| cts_n | input | 1 | Active-low clear-to-send input (asynchronous) |
| rts_n | output | 1 | Active-low request-to-send |
| txd | output | 1 | Serial data, idle high |
| buf_valid | input | 1 | Buffer byte available |
| buf_data | input | DATA_W | Buffer byte |
| buf_last | input | 1 | Byte is the last of its buffer |
| buf_frame_end | input | 1 | Buffer closes the frame (checked with buf_last) |
| buf_ready | output | 1 | Byte accepted this cycle |
| done_vld | output | 1 | One-cycle status pulse per buffer |
| done_err | output | 1 | Status carries CTS-lost |

## Verification
On every cycle, the assertions check that RTS falls only when CTS, the gap counter and the sync gate all allow it. They also check that an unusable CTS during RTS releases it on the next edge, that TXD is idle whenever RTS is high, and that TXD moves only on a bit pulse or an abort. The exact bit order, the single lead bit, gapless chaining of buffers, the length of the inter-frame gap, draining after an abort and sticky sync can only be shown by the bench's scenarios. The bench decodes the captured line for these.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_HOLD,
    ST_DRAIN
  } ttx_state_e;

  localparam logic [1:0] DIAG_SOFT = 2'b11;

  // CTS as seen by the transmitter: forced low in software mode
  function automatic logic cts_effective(input logic [1:0] diag, input logic cts_n_sync);
    return (diag == DIAG_SOFT) || !cts_n_sync;
  endfunction

  // Idle gap satisfied once the counted idle bit times reach the minimum
  function automatic logic gap_met(input int unsigned cnt, input int unsigned need);
    return cnt >= need;
  endfunction

endpackage

// File: rtl/ttx_sync.sv
module ttx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ttx_shifter.sv
module ttx_shifter #(
  parameter int DW = 8,
  localparam int CNTW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          bit_out,
  output logic          last_bit
);
  logic [DW-1:0]   sreg_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      cnt_q  <= '0;
    end else if (load) begin
      sreg_q <= din;
      cnt_q  <= '0;
    end else if (shift) begin
      sreg_q <= {1'b1, sreg_q[DW-1:1]};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign bit_out  = sreg_q[0];
  assign last_bit = (cnt_q == CNTW'(DW - 1));
endmodule

// File: rtl/ttx_gap.sv
module ttx_gap import ttx_pkg::*; #(
  parameter int GAP_BITS = 17,
  localparam int CW = $clog2(GAP_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic ready
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cnt_q <= CW'(GAP_BITS);
    else if (clear)                               cnt_q <= '0;
    else if (tick && (cnt_q < CW'(GAP_BITS)))     cnt_q <= cnt_q + 1'b1;
  end

  assign ready = gap_met(int'(cnt_q), GAP_BITS);
endmodule

// File: rtl/ttx_top.sv
module ttx_top import ttx_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int GAP_BITS    = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        mode_diag,
  input  logic              sync_en,
  input  logic              sync_n,
  input  logic              cts_n,
  output logic              rts_n,
  output logic              txd,
  input  logic              buf_valid,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_last,
  input  logic              buf_frame_end,
  output logic              buf_ready,
  output logic              done_vld,
  output logic              done_err
);
  ttx_state_e state_q, state_d;

  logic cts_q, sync_q, sync_seen_q;
  logic cts_ok_w, sync_ok_w, gap_ok_w, tx_active_w;
  logic start_w, abort_w, byte_end_w, load_w, shift_w, drain_pop_w, gap_clr_w;
  logic sh_bit, sh_last;
  logic cur_last_q, cur_fend_q;
  logic done_vld_q, done_err_q;

  ttx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_q)
  );

  ttx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_n), .q(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sync_seen_q <= 1'b0;
    else if (!sync_en) sync_seen_q <= 1'b0;
    else if (!sync_q)  sync_seen_q <= 1'b1;
  end

  assign cts_ok_w    = cts_effective(mode_diag, cts_q);
  assign sync_ok_w   = !sync_en || sync_seen_q;
  assign tx_active_w = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_HOLD);

  // Event wires
  assign abort_w     = tx_active_w && !cts_ok_w;
  assign start_w     = (state_q == ST_IDLE) && bit_en && buf_valid &&
                       cts_ok_w && sync_ok_w && gap_ok_w;
  assign byte_end_w  = (state_q == ST_SHIFT) && bit_en && sh_last && !abort_w;
  assign shift_w     = (state_q == ST_SHIFT) && bit_en && !sh_last && !abort_w;
  assign load_w      = !abort_w && bit_en && buf_valid &&
                       ((state_q == ST_LEAD) || (state_q == ST_HOLD) ||
                        (byte_end_w && !cur_fend_q));
  assign drain_pop_w = (state_q == ST_DRAIN) && buf_valid;
  assign gap_clr_w   = (byte_end_w && cur_fend_q) || abort_w;

  ttx_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_w), .shift(shift_w),
    .din(buf_data), .bit_out(sh_bit), .last_bit(sh_last)
  );

  ttx_gap #(.GAP_BITS(GAP_BITS)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(gap_clr_w), .tick(bit_en), .ready(gap_ok_w)
  );

  always_comb begin
    state_d = state_q;
    if (abort_w) begin
      state_d = ((state_q == ST_SHIFT) && cur_fend_q) ? ST_IDLE : ST_DRAIN;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_w) state_d = ST_LEAD;
        ST_LEAD,
        ST_HOLD:  if (load_w) state_d = ST_SHIFT;
        ST_SHIFT: if (byte_end_w) begin
                    if (cur_fend_q)  state_d = ST_IDLE;
                    else if (!load_w) state_d = ST_HOLD;
                  end
        ST_DRAIN: if (drain_pop_w && buf_last && buf_frame_end) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_last_q <= 1'b0;
      cur_fend_q <= 1'b0;
      done_vld_q <= 1'b0;
      done_err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_w) begin
        cur_last_q <= buf_last;
        cur_fend_q <= buf_last && buf_frame_end;
      end
      done_vld_q <= (byte_end_w && cur_last_q) || abort_w;
      done_err_q <= abort_w;
    end
  end

  assign rts_n     = !tx_active_w;
  assign txd       = (state_q == ST_SHIFT) ? sh_bit : 1'b1;
  assign buf_ready = load_w || drain_pop_w;
  assign done_vld  = done_vld_q;
  assign done_err  = done_err_q;
endmodule

// File: rtl/ttx_checker.sv
module ttx_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic rts_n,
  input logic txd,
  input logic buf_valid,
  input logic buf_ready,
  input logic done_vld,
  input logic done_err,
  input logic cts_ok_w,
  input logic gap_ok_w,
  input logic sync_ok_w,
  input logic abort_w
);
  a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n |-> txd);

  a_r2_rts_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> $past(cts_ok_w));

  a_r3_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !abort_w) |=> $stable(txd));

  a_r4_err_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done_vld);

  a_r4_ready_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> buf_valid);

  a_r6_gap_before_rts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> $past(gap_ok_w));

  a_r7_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_n && !cts_ok_w) |=> rts_n);

  a_r9_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> $past(sync_ok_w));
endmodule

bind ttx_top ttx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rts_n(rts_n), .txd(txd),
  .buf_valid(buf_valid), .buf_ready(buf_ready), .done_vld(done_vld),
  .done_err(done_err), .cts_ok_w(cts_ok_w), .gap_ok_w(gap_ok_w),
  .sync_ok_w(sync_ok_w), .abort_w(abort_w)
);

// File: tb/tb_ttx_top.sv
module tb_ttx_top;
  localparam int CLK_PERIOD = 10;
  localparam int BITCLK     = 4;
  localparam int RECMAX     = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div = '0;
  logic       bit_en;
  logic [1:0] mode_diag = 2'b00;
  logic       sync_en = 1'b0, sync_n = 1'b1, cts_n = 1'b0;
  logic       rts_n, txd, buf_ready, done_vld, done_err;
  logic       buf_valid = 1'b0, buf_last = 1'b0, buf_frame_end = 1'b0;
  logic [7:0] buf_data = '0;

  int tests = 0, fails = 0;
  int dn_cnt = 0, err_cnt = 0;
  logic rec_on = 1'b0;
  logic rec_rts [RECMAX];
  logic rec_txd [RECMAX];
  int   rec_n = 0;
  int   runs;
  int   run_start [4];
  int   run_len [4];
  logic drv_busy = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign bit_en = rst_n && (div == 2'd0);

  ttx_top dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode_diag(mode_diag),
    .sync_en(sync_en), .sync_n(sync_n), .cts_n(cts_n), .rts_n(rts_n), .txd(txd),
    .buf_valid(buf_valid), .buf_data(buf_data), .buf_last(buf_last),
    .buf_frame_end(buf_frame_end), .buf_ready(buf_ready),
    .done_vld(done_vld), .done_err(done_err)
  );

  // one line sample per bit time, two clocks after the bit pulse edge
  always @(negedge clk) begin
    if (rec_on && div == 2'd2 && rec_n < RECMAX) begin
      rec_rts[rec_n] = rts_n;
      rec_txd[rec_n] = txd;
      rec_n = rec_n + 1;
    end
    if (done_vld) dn_cnt = dn_cnt + 1;
    if (done_err) err_cnt = err_cnt + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BITCLK) @(posedge clk);
  endtask

  task automatic start_cap();
    @(posedge clk);
    rec_n = 0; rec_on = 1'b1; dn_cnt = 0; err_cnt = 0;
  endtask

  task automatic send_buf(input logic [31:0] d, input int n, input logic lflag);
    drv_busy = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      buf_valid = 1'b1; buf_data = d[8*k +: 8];
      buf_last = (k == n - 1); buf_frame_end = lflag;
      #1;
      while (!buf_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    buf_valid = 1'b0; buf_last = 1'b0; buf_frame_end = 1'b0;
    drv_busy = 1'b0;
  endtask

  task automatic analyze();
    runs = 0;
    for (int r = 0; r < 4; r++) begin run_start[r] = 0; run_len[r] = 0; end
    for (int i = 0; i < rec_n; i++) begin
      if (!rec_rts[i]) begin
        if (i == 0 || rec_rts[i-1]) begin
          if (runs < 4) run_start[runs] = i;
          runs++;
        end
        if (runs <= 4) run_len[runs-1]++;
      end
    end
  endtask

  function automatic logic [7:0] got_byte(input int r, input int b);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[j] = rec_txd[run_start[r] + 1 + 8*b + j];
    return v;
  endfunction

  // table: [31:24] byte count, [23:0] bytes with the first byte at [7:0]
  localparam logic [31:0] VEC [6] = '{
    32'h01_00_00_5A, 32'h01_00_00_00, 32'h01_00_00_FF,
    32'h02_00_81_3C, 32'h03_C3_10_7E, 32'h03_12_34_56
  };

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, gap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(rts_n === 1'b1, "R1 rts after reset", rts_n, 1);
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(buf_ready === 1'b0, "R1 ready after reset", buf_ready, 0);
    chk(done_vld === 1'b0, "R1 done after reset", done_vld, 0);
    rst_n = 1'b1;
    wait_bits(4);

    // R3/R4: table of single-buffer frames
    for (int e = 0; e < 6; e++) begin
      v = VEC[e]; n = int'(v[31:24]);
      start_cap();
      send_buf({8'h00, v[23:0]}, n, 1'b1);
      wait_bits(8 * n + 25);
      rec_on = 1'b0;
      analyze();
      chk(runs == 1, "R4 one rts run", runs, 1);
      chk(run_len[0] == 1 + 8 * n, "R4 rts low length", run_len[0], 1 + 8 * n);
      chk(rec_txd[run_start[0]] === 1'b1, "R3 lead bit idle", rec_txd[run_start[0]], 1);
      for (int b = 0; b < n; b++)
        chk(got_byte(0, b) == v[8*b +: 8], "R3 byte LSB first", got_byte(0, b), v[8*b +: 8]);
      chk(dn_cnt == 1 && err_cnt == 0, "R4 one clean done", dn_cnt * 10 + err_cnt, 10);
    end

    // R5: chained buffers, first with frame end clear
    start_cap();
    send_buf(32'h0000_E11D, 2, 1'b0);
    send_buf(32'h0000_00B4, 1, 1'b1);
    wait_bits(50);
    rec_on = 1'b0;
    analyze();
    chk(runs == 1, "R5 rts held across buffers", runs, 1);
    chk(run_len[0] == 25, "R5 no gap between buffers", run_len[0], 25);
    chk(got_byte(0, 1) == 8'hE1, "R5 first buffer byte", got_byte(0, 1), 8'hE1);
    chk(got_byte(0, 2) == 8'hB4, "R5 chained byte", got_byte(0, 2), 8'hB4);
    chk(dn_cnt == 2, "R4 done per buffer", dn_cnt, 2);

    // R6: two separate frames
    start_cap();
    send_buf(32'h0000_00A1, 1, 1'b1);
    send_buf(32'h0000_0042, 1, 1'b1);
    wait_bits(60);
    rec_on = 1'b0;
    analyze();
    gap = run_start[1] - (run_start[0] + run_len[0]);
    chk(runs == 2, "R6 two frames", runs, 2);
    chk(gap >= 17 && gap <= 19, "R6 idle gap", gap, 17);
    chk(got_byte(1, 0) == 8'h42, "R6 second frame data", got_byte(1, 0), 8'h42);

    // R2: CTS high holds off
    cts_n = 1'b1;
    start_cap();
    fork send_buf(32'h0000_0066, 1, 1'b1); join_none
    wait_bits(30);
    analyze();
    chk(runs == 0, "R2 no rts without cts", runs, 0);
    chk(drv_busy == 1'b1, "R2 buffer not consumed", drv_busy, 1);
    cts_n = 1'b0;
    wait_bits(40);
    rec_on = 1'b0;
    analyze();
    chk(runs == 1 && got_byte(0, 0) == 8'h66, "R2 sends after cts", got_byte(0, 0), 8'h66);

    // R7: abort on CTS loss
    start_cap();
    fork send_buf(32'h4433_2211, 4, 1'b1); join_none
    wait (rts_n == 1'b0);
    wait_bits(12);
    @(negedge clk); cts_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rts_n === 1'b1, "R7 rts released", rts_n, 1);
    chk(txd === 1'b1, "R7 txd idle", txd, 1);
    wait_bits(20);
    rec_on = 1'b0;
    analyze();
    chk(err_cnt == 1 && dn_cnt == 1, "R7 error status", err_cnt, 1);
    chk(drv_busy == 1'b0, "R7 rest of frame drained", drv_busy, 0);
    chk(run_len[0] < 33, "R7 frame cut short", run_len[0], 14);
    cts_n = 1'b0;
    wait_bits(25);

    // R8: software mode ignores CTS
    mode_diag = 2'b11; cts_n = 1'b1;
    start_cap();
    send_buf(32'h0000_00C5, 1, 1'b1);
    wait_bits(35);
    rec_on = 1'b0;
    analyze();
    chk(runs == 1 && got_byte(0, 0) == 8'hC5, "R8 sent with cts high", got_byte(0, 0), 8'hC5);
    chk(err_cnt == 0, "R8 no abort", err_cnt, 0);
    mode_diag = 2'b00; cts_n = 1'b0;
    wait_bits(25);

    // R9: external sync gate
    sync_en = 1'b1; sync_n = 1'b1;
    start_cap();
    fork send_buf(32'h0000_0093, 1, 1'b1); join_none
    wait_bits(30);
    analyze();
    chk(runs == 0, "R9 waits for sync", runs, 0);
    sync_n = 1'b0;
    wait_bits(40);
    analyze();
    chk(runs == 1 && got_byte(0, 0) == 8'h93, "R9 sent after sync", got_byte(0, 0), 8'h93);
    chk(rec_txd[run_start[0]] === 1'b1, "R9 one lead bit", rec_txd[run_start[0]], 1);
    sync_n = 1'b1;
    wait_bits(4);
    start_cap();
    send_buf(32'h0000_0027, 1, 1'b1);
    wait_bits(35);
    rec_on = 1'b0;
    analyze();
    chk(runs == 1 && got_byte(0, 0) == 8'h27, "R9 sync sticky", got_byte(0, 0), 8'h27);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule